// File: doc/BRIEF.md
# Overrange-Driven Step Attenuator Gain Control

This block closes a simple gain loop in front of a bank of parallel ADC channels. On each clock it looks at every channel's overrange flag and at the two top bits of the channel's offset-binary sample. It keeps these observations over a window of a programmable number of cycles. At the last cycle of each window it moves a 5-bit attenuation code by at most one 1 dB step. An overrange on any channel raises the attenuation. If no channel produced a large sample and no channel overranged, the attenuation is lowered. In every other case the code holds.

The code drives a parallel digital step attenuator with a range of 2 dB to 32 dB. A one-cycle strobe marks each new code, so the attenuator's control latch loads only on a real change. After reset the loop starts at full attenuation, so the first signals seen after power-up cannot overdrive the converters.

Top module: `agc_atten_ctrl`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `atten_code` is 30 (32 dB) and `atten_upd` is 0.
- R2: `atten_code` equals the attenuation in dB minus 2. Its value always stays within 0 (2 dB) to 30 (32 dB).
- R3: If any channel's `adc_ovr` bit is 1 on any cycle of a window, the code increases by one at the end of that window.
- R4: A sample counts as large when its two most significant bits are `11` or `00`, that is, near either extreme of offset binary. If no channel is large and no channel overranges on any cycle of a window, the code decreases by one at the end of that window.
- R5: If at least one channel is large on some cycle of the window and no overrange occurs, the code is unchanged. One large channel is enough to hold the code.
- R6: Overrange has priority. A window that contains both overrange and no large sample still increases the code.
- R7: The code saturates at 30 and at 0 and never wraps. A step request at a limit leaves the code and the strobe unchanged.
- R8: A window lasts `win_len` cycles, and a value of 0 is treated as 1. Counting starts from the first clock after reset. The step is applied on the window's last clock edge and is visible after that edge. The code never changes in the middle of a window.
- R9: `atten_upd` is high for exactly one cycle, together with the new code, whenever the code changes. It is low at all other times.
- R10: An event on a single cycle of a window counts for the whole window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_len | input | 16 | Window length in cycles (0 acts as 1) |
| adc_ovr | input | 8 | Overrange flag, one per channel |
| adc_data | input | 64 | Offset-binary samples, channel i at bits [8i+7:8i] |
| atten_code | output | 5 | Attenuation code, dB minus 2 |
| atten_upd | output | 1 | One-cycle strobe on each code change |

## Verification
The bench targets the two saturation limits. A design that wraps at a limit would jump from 30 to 0 or from 0 to 30, and a design that strobes at a limit would pulse the strobe with no change.

It uses samples whose top bits are `00`, `01`, `10` and `11`. A magnitude test that looks only at the top `11` case would treat low-extreme samples as small and lower the gain wrongly.

It checks windows where overrange and quiet signals coincide, and windows where an event lasts only one cycle. A design without priority, or one that sees only the last cycle of a window, would hold or step the wrong way.

It also checks the code in mid-window and with a zero window length. Off-by-one window counting shows up as an early step or as a stall.

// File: rtl/agc_pkg.sv
package agc_pkg;
  // default geometry of the gain loop
  localparam int N_CH_D    = 8;
  localparam int SAMP_W_D  = 8;
  localparam int WIN_W_D   = 16;
  localparam int MIN_DB_D  = 2;
  localparam int MAX_DB_D  = 32;

  // step request produced at a window boundary
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // number of bits needed for a code spanning 0..span
  function automatic int code_bits(input int span);
    int b;
    b = 1;
    while ((1 << b) <= span) b++;
    return b;
  endfunction
endpackage

// File: rtl/agc_chan_detect.sv
module agc_chan_detect #(
  parameter int N_CH   = agc_pkg::N_CH_D,
  parameter int SAMP_W = agc_pkg::SAMP_W_D
) (
  input  logic [N_CH-1:0]        ovr,
  input  logic [N_CH*SAMP_W-1:0] data,
  output logic                   any_ovr,
  output logic                   any_big
);
  localparam int TOP = SAMP_W - 1;

  logic [N_CH-1:0] big;

  // a sample is large when its two top bits agree: near either rail
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [1:0] hi;
    assign hi     = data[c*SAMP_W + TOP -: 2];
    assign big[c] = (hi[1] == hi[0]);
  end

  assign any_ovr = |ovr;
  assign any_big = |big;
endmodule

// File: rtl/agc_window_acc.sv
module agc_window_acc #(
  parameter int WIN_W = agc_pkg::WIN_W_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_len,
  input  logic             any_ovr,
  input  logic             any_big,
  output logic             win_end,
  output logic             saw_ovr,
  output logic             saw_big
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] len_eff;
  logic [WIN_W-1:0] last_idx;
  logic             acc_ovr_q;
  logic             acc_big_q;

  always_comb begin
    len_eff  = (win_len == '0) ? {{(WIN_W-1){1'b0}}, 1'b1} : win_len;
    last_idx = len_eff - {{(WIN_W-1){1'b0}}, 1'b1};
    win_end  = (cnt_q >= last_idx);
    saw_ovr  = acc_ovr_q | any_ovr;
    saw_big  = acc_big_q | any_big;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      acc_ovr_q <= 1'b0;
      acc_big_q <= 1'b0;
    end else if (win_end) begin
      cnt_q     <= '0;
      acc_ovr_q <= 1'b0;
      acc_big_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_q + {{(WIN_W-1){1'b0}}, 1'b1};
      acc_ovr_q <= saw_ovr;
      acc_big_q <= saw_big;
    end
  end
endmodule

// File: rtl/agc_code_step.sv
module agc_code_step #(
  parameter int CODE_W   = 5,
  parameter int CODE_MAX = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_end,
  input  logic              saw_ovr,
  input  logic              saw_big,
  output logic [CODE_W-1:0] code,
  output logic              upd
);
  import agc_pkg::*;

  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

  step_e             req;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_nx;
  logic              upd_q;

  // overrange wins; quiet lowers; any large sample holds
  always_comb begin
    if (!win_end)     req = STEP_HOLD;
    else if (saw_ovr) req = STEP_UP;
    else if (!saw_big) req = STEP_DOWN;
    else              req = STEP_HOLD;
  end

  always_comb begin
    code_nx = code_q;
    case (req)
      STEP_UP:   if (code_q < TOP_CODE) code_nx = code_q + ONE;
      STEP_DOWN: if (code_q != '0)      code_nx = code_q - ONE;
      default:   code_nx = code_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= TOP_CODE;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_nx;
      upd_q  <= (code_nx != code_q);
    end
  end

  assign code = code_q;
  assign upd  = upd_q;
endmodule

// File: rtl/agc_atten_ctrl.sv
module agc_atten_ctrl #(
  parameter int N_CH   = agc_pkg::N_CH_D,
  parameter int SAMP_W = agc_pkg::SAMP_W_D,
  parameter int WIN_W  = agc_pkg::WIN_W_D,
  parameter int MIN_DB = agc_pkg::MIN_DB_D,
  parameter int MAX_DB = agc_pkg::MAX_DB_D,
  parameter int CODE_W = agc_pkg::code_bits(MAX_DB - MIN_DB)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WIN_W-1:0]       win_len,
  input  logic [N_CH-1:0]        adc_ovr,
  input  logic [N_CH*SAMP_W-1:0] adc_data,
  output logic [CODE_W-1:0]      atten_code,
  output logic                   atten_upd
);
  localparam int CODE_MAX = MAX_DB - MIN_DB;

  logic any_ovr, any_big;
  logic win_end, saw_ovr, saw_big;

  agc_chan_detect #(.N_CH(N_CH), .SAMP_W(SAMP_W)) u_det (
    .ovr     (adc_ovr),
    .data    (adc_data),
    .any_ovr (any_ovr),
    .any_big (any_big)
  );

  agc_window_acc #(.WIN_W(WIN_W)) u_win (
    .clk     (clk),
    .rst     (rst),
    .win_len (win_len),
    .any_ovr (any_ovr),
    .any_big (any_big),
    .win_end (win_end),
    .saw_ovr (saw_ovr),
    .saw_big (saw_big)
  );

  agc_code_step #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_step (
    .clk     (clk),
    .rst     (rst),
    .win_end (win_end),
    .saw_ovr (saw_ovr),
    .saw_big (saw_big),
    .code    (atten_code),
    .upd     (atten_upd)
  );
endmodule

// File: rtl/agc_atten_ctrl_chk.sv
module agc_atten_ctrl_chk #(
  parameter int CODE_W   = 5,
  parameter int CODE_MAX = 30
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] atten_code,
  input logic              atten_upd
);
  // R2: code stays inside the legal span
  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    atten_code <= CODE_W'(CODE_MAX));

  // R7 / R8: never more than one step per cycle, so no wrap
  a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
    (atten_code == $past(atten_code)) ||
    (atten_code == $past(atten_code) + CODE_W'(1)) ||
    (atten_code + CODE_W'(1) == $past(atten_code)));

  // R9: strobe only with a change
  a_r9_upd_means_change: assert property (@(posedge clk) disable iff (rst)
    atten_upd |-> (atten_code != $past(atten_code)));

  // R9: change always strobed
  a_r9_change_means_upd: assert property (@(posedge clk) disable iff (rst)
    (atten_code != $past(atten_code)) |-> atten_upd);

  // R1: reset value is full attenuation
  a_r1_reset_value: assert property (@(posedge clk)
    $past(rst) |-> (atten_code == CODE_W'(CODE_MAX) && !atten_upd));
endmodule

bind agc_atten_ctrl agc_atten_ctrl_chk #(
  .CODE_W   (CODE_W),
  .CODE_MAX (MAX_DB - MIN_DB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .atten_code (atten_code),
  .atten_upd  (atten_upd)
);

// File: tb/tb_agc_atten_ctrl.sv
module tb_agc_atten_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH   = 8;
  localparam int SAMP_W = 8;
  localparam int WIN_W  = 16;
  localparam int CODE_W = 5;
  localparam int L      = 4;
  localparam int NVEC   = 10;

  // {ovr mask, sample for every channel, expected code after one window}
  localparam logic [20:0] VEC [NVEC] = '{
    {8'h00, 8'h80, 5'd29},  // R4 quiet -> down
    {8'h00, 8'h80, 5'd28},  // R4
    {8'h00, 8'hC5, 5'd28},  // R5 top bits 11 -> hold
    {8'h00, 8'h10, 5'd28},  // R5 top bits 00 -> hold
    {8'h00, 8'h40, 5'd27},  // R4 top bits 01 is small
    {8'h01, 8'h80, 5'd28},  // R6 ovr beats quiet
    {8'h80, 8'hFF, 5'd29},  // R3
    {8'h00, 8'h7F, 5'd28},  // R4
    {8'h00, 8'hBF, 5'd27},  // R4 top bits 10 is small
    {8'h10, 8'h00, 5'd28}   // R3
  };

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [WIN_W-1:0]       win_len = WIN_W'(L);
  logic [N_CH-1:0]        adc_ovr = '0;
  logic [N_CH*SAMP_W-1:0] adc_data = '0;
  logic [CODE_W-1:0]      atten_code;
  logic                   atten_upd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_atten_ctrl dut (
    .clk(clk), .rst(rst), .win_len(win_len), .adc_ovr(adc_ovr),
    .adc_data(adc_data), .atten_code(atten_code), .atten_upd(atten_upd)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] ovr, input logic [7:0] s);
    adc_ovr  = ovr;
    adc_data = {N_CH{s}};
  endtask

  // one window of constant stimulus; ends at the negedge after the last edge
  task automatic window(input logic [7:0] ovr, input logic [7:0] s, input int len);
    for (int i = 0; i < len; i++) begin
      drive(ovr, s);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(8'h00, 8'h80);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int prev;
    win_len = WIN_W'(L);
    do_reset();
    // R1
    check("R1 reset code", atten_code, 30);
    check("R1 reset strobe", atten_upd, 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      prev = atten_code;
      window(VEC[v][20:13], VEC[v][12:5], L);
      check("R3-R6 table code", atten_code, VEC[v][4:0]);
      check("R9 table strobe", atten_upd, (prev != VEC[v][4:0]) ? 1 : 0);
    end

    // R5: one large channel among quiet ones holds
    prev = atten_code;
    for (int i = 0; i < L; i++) begin
      adc_ovr = '0;
      adc_data = {{(N_CH-1){8'h80}}, 8'hF0};
      @(posedge clk); @(negedge clk);
    end
    check("R5 single large channel", atten_code, prev);

    // R8: no change mid window
    prev = atten_code;
    for (int i = 0; i < L-1; i++) begin
      drive(8'h00, 8'h80);
      @(posedge clk); @(negedge clk);
    end
    check("R8 mid window hold", atten_code, prev);
    drive(8'h00, 8'h80);
    @(posedge clk); @(negedge clk);
    check("R8 step at window end", atten_code, prev - 1);

    // R10: one-cycle overrange counts for whole window
    prev = atten_code;
    drive(8'h04, 8'h80);
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < L-1; i++) begin
      drive(8'h00, 8'h80);
      @(posedge clk); @(negedge clk);
    end
    check("R10 brief overrange", atten_code, prev + 1);
    // R10: one-cycle large sample holds
    prev = atten_code;
    drive(8'h00, 8'h03);
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < L-1; i++) begin
      drive(8'h00, 8'h80);
      @(posedge clk); @(negedge clk);
    end
    check("R10 brief large", atten_code, prev);

    // R7: top saturation
    do_reset();
    window(8'hFF, 8'hFF, L);
    check("R7 top clamp code", atten_code, 30);
    check("R7 top clamp strobe", atten_upd, 0);

    // R7: bottom saturation
    for (int w = 0; w < 32; w++) window(8'h00, 8'h80, L);
    check("R7 bottom reach", atten_code, 0);
    window(8'h00, 8'h80, L);
    check("R7 bottom clamp code", atten_code, 0);
    check("R7 bottom clamp strobe", atten_upd, 0);
    window(8'h02, 8'h80, L);
    check("R3 up from bottom", atten_code, 1);
    check("R9 strobe on change", atten_upd, 1);
    drive(8'h00, 8'hC0);
    @(posedge clk); @(negedge clk);
    check("R9 strobe one cycle", atten_upd, 0);

    // R8: zero length acts as one cycle
    do_reset();
    win_len = '0;
    window(8'h00, 8'h80, 1);
    check("R8 zero length step", atten_code, 29);
    window(8'h00, 8'h80, 1);
    check("R8 zero length second", atten_code, 28);
    check("R2 code tracks dB", atten_code + 2, 30);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule